// File: doc/BRIEF.md
# GPIO Edge and Level Interrupt Unit

This block watches a parameterised set of general-purpose input pins, organised in banks of 32, and turns selected transitions or levels on them into interrupts. Every pin passes through a two-flop synchroniser and then through a per-pin inversion stage. After that, four independent trigger conditions can be enabled for each pin: rising edge, falling edge, high level and low level.

Edge events are latched in a sticky pending word. A second sticky word records whether a rising edge was among the events. Level conditions are not latched: they show in the status word only while the level holds. The OR of every status bit drives a single interrupt line.

Software reaches the configuration and status through a flat register port. The address is `{bank, select}`, where select is the low three bits and bank is the bits above them. Writes take effect at the clock edge. Reads are combinational.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0.
- R2: Suppose a rising-edge enable (select 0) is set and the pin rises. Count the clock edge that first samples the new pin value as edge 1. Then the pin's bit appears in status (select 5) and in edge-kind (select 6) after edge 3, and is still 0 after edge 2.
- R3: Suppose a falling-edge enable (select 1) is set and the pin falls. Then the pin's status bit is set and its edge-kind bit stays 0.
- R4: An edge whose enable is 0 leaves the status unchanged.
- R5: With the high-level enable (select 2) set, the status bit is 1 after edge 2 while the pin is high. Writing 1 to status does not clear it. The bit returns to 0 once the pin is low.
- R6: With the low-level enable (select 3) set, the status bit is 1 while the pin is low and 0 while it is high.
- R7: High and low enables of one pin are never both 1. Writing a 1 to a high-enable bit clears the matching low-enable bit. A low-enable bit written as 1 stays 0 where the high enable is set.
- R8: The invert bit (select 4) inverts the pin before detection. With inversion and rising-edge enable both set, a falling pin raises the interrupt and records a rising edge.
- R9: Edge pending bits in status are sticky. Writing 1 to select 5 clears them and writing 0 leaves them. Edge-kind bits are sticky as well and are cleared only by writing 1 to select 6.
- R10: When a status clear and a new enabled edge on the same pin fall in the same cycle, the status bit remains set.
- R11: `irq_o` is 1 exactly when any status bit in any bank is 1.
- R12: Banks are independent: bank b holds pins 32b to 32b+31. Select 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NBANKS*BANK_W | Asynchronous pin inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | {bank, select[2:0]} |
| reg_wdata | input | BANK_W | Write data |
| reg_rdata | output | BANK_W | Read data for reg_addr |
| irq_o | output | 1 | Combined interrupt |

## Verification
The two functions that can collide are the software clear of a pending edge bit and the hardware setting of that same bit by a new edge. To provoke the collision, the bench raises a pin and counts two synchroniser edges. It then issues the write-one-to-clear so that the write lands on the same edge at which the event is latched. The bench judges the outcome by reading status afterwards: the bit must still be 1. A second clear, with no new edge, must then bring the bit to 0.

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int NBANKS = 2,
  parameter int BANK_W = 32,
  localparam int NP = NBANKS * BANK_W,
  localparam int BSEL_W = (NBANKS > 1) ? $clog2(NBANKS) : 1,
  localparam int ADDR_W = 3 + ((NBANKS > 1) ? $clog2(NBANKS) : 0)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NP-1:0]     pin_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BANK_W-1:0] reg_wdata,
  output logic [BANK_W-1:0] reg_rdata,
  output logic              irq_o
);
  logic [NP-1:0] s1, s2, pv, rise_en, fall_en, hi_en, lo_en, inv;
  logic [NP-1:0] edge_pend, edge_kind, clr_pend, clr_kind;
  logic [NP-1:0] lvl, ev_rise, ev_any, lvl_act, status;
  logic [BSEL_W-1:0] bsel;
  logic [2:0] sel;

  assign sel = reg_addr[2:0];
  generate
    if (NBANKS > 1) begin : g_multi
      assign bsel = reg_addr[ADDR_W-1:3];
    end else begin : g_single
      assign bsel = '0;
    end
  endgenerate

  assign lvl     = s2 ^ inv;
  assign ev_rise = lvl & ~pv & rise_en;
  assign ev_any  = ev_rise | (~lvl & pv & fall_en);
  assign lvl_act = (hi_en & lvl) | (lo_en & ~lvl);
  assign status  = edge_pend | lvl_act;
  assign irq_o   = |status;

  always_comb begin
    clr_pend = '0;
    clr_kind = '0;
    for (int b = 0; b < NBANKS; b++) begin
      if (reg_we && bsel == BSEL_W'(b)) begin
        if (sel == 3'd5) clr_pend[b*BANK_W +: BANK_W] = reg_wdata;
        if (sel == 3'd6) clr_kind[b*BANK_W +: BANK_W] = reg_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; pv <= '0;
      rise_en <= '0; fall_en <= '0; hi_en <= '0; lo_en <= '0; inv <= '0;
      edge_pend <= '0; edge_kind <= '0;
    end else begin
      s1 <= pin_i;
      s2 <= s1;
      pv <= lvl;
      edge_pend <= (edge_pend & ~clr_pend) | ev_any;
      edge_kind <= (edge_kind & ~clr_kind) | ev_rise;
      for (int b = 0; b < NBANKS; b++) begin
        if (reg_we && bsel == BSEL_W'(b)) begin
          case (sel)
            3'd0: rise_en[b*BANK_W +: BANK_W] <= reg_wdata;
            3'd1: fall_en[b*BANK_W +: BANK_W] <= reg_wdata;
            3'd2: begin
              hi_en[b*BANK_W +: BANK_W] <= reg_wdata;
              lo_en[b*BANK_W +: BANK_W] <= lo_en[b*BANK_W +: BANK_W] & ~reg_wdata;
            end
            3'd3: lo_en[b*BANK_W +: BANK_W] <= reg_wdata & ~hi_en[b*BANK_W +: BANK_W];
            3'd4: inv[b*BANK_W +: BANK_W] <= reg_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NBANKS; b++) begin
      if (bsel == BSEL_W'(b)) begin
        case (sel)
          3'd0: reg_rdata = rise_en[b*BANK_W +: BANK_W];
          3'd1: reg_rdata = fall_en[b*BANK_W +: BANK_W];
          3'd2: reg_rdata = hi_en[b*BANK_W +: BANK_W];
          3'd3: reg_rdata = lo_en[b*BANK_W +: BANK_W];
          3'd4: reg_rdata = inv[b*BANK_W +: BANK_W];
          3'd5: reg_rdata = status[b*BANK_W +: BANK_W];
          3'd6: reg_rdata = edge_kind[b*BANK_W +: BANK_W];
          default: reg_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk #(
  parameter int NP = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [NP-1:0] hi_en,
  input logic [NP-1:0] lo_en,
  input logic [NP-1:0] lvl,
  input logic [NP-1:0] edge_pend,
  input logic [NP-1:0] ev_any,
  input logic [NP-1:0] status,
  input logic          irq_o
);
  // R7
  hilo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_en & lo_en) == '0);

  // R9
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ((edge_pend & $past(edge_pend)) == $past(edge_pend)));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_any != '0) |=> ((edge_pend & $past(ev_any)) == $past(ev_any)));

  // R11
  pend_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_pend != '0) |-> irq_o);

  // R5
  level_shown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hi_en & lvl) & ~status) == '0);
endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.NP(NP)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .hi_en(hi_en), .lo_en(lo_en),
  .lvl(lvl), .edge_pend(edge_pend), .ev_any(ev_any), .status(status), .irq_o(irq_o)
);

// File: tb/sim_gpio_irq_unit.sv
`timescale 1ns/1ps
module sim_gpio_irq_unit;
  localparam int NB = 2;
  localparam int BW = 32;
  logic clk = 0, rst_n = 0, we = 0, irq;
  logic [NB*BW-1:0] pins = '0;
  logic [3:0] addr = '0;
  logic [BW-1:0] wdata = '0, rdata, v;
  int errors = 0, checks = 0;

  gpio_irq_unit #(.NBANKS(NB), .BANK_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq));

  always #4 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int bank, input int sel, input logic [31:0] d);
    addr = 4'(bank * 8 + sel); wdata = d; we = 1;
    @(negedge clk);
    we = 0; wdata = '0;
  endtask

  task automatic rd(input int bank, input int sel, output logic [31:0] d);
    addr = 4'(bank * 8 + sel);
    #1 d = rdata;
  endtask

  task automatic t_reset;
    for (int b = 0; b < NB; b++)
      for (int s = 0; s < 8; s++) begin
        rd(b, s, v); check("R1 reset register", v, 0);
      end
    check("R1 reset irq", {31'd0, irq}, 0);
  endtask

  task automatic t_rise;
    wr(0, 0, 32'h1);
    pins[0] = 1;
    step(2); rd(0, 5, v); check("R2 not yet after edge 2", v, 0);
    step(1); rd(0, 5, v); check("R2 status after edge 3", v, 1);
    rd(0, 6, v); check("R2 edge kind rising", v, 1);
    check("R11 irq on edge", {31'd0, irq}, 1);
    wr(0, 5, 32'h0); rd(0, 5, v); check("R9 write 0 keeps", v, 1);
    wr(0, 5, 32'h1); rd(0, 5, v); check("R9 W1C status", v, 0);
    rd(0, 6, v); check("R9 kind independent of status clear", v, 1);
    wr(0, 6, 32'h1); rd(0, 6, v); check("R9 W1C kind", v, 0);
    check("R11 irq low after clear", {31'd0, irq}, 0);
  endtask

  task automatic t_fall;
    wr(0, 1, 32'h2);
    pins[1] = 1; step(3); rd(0, 5, v); check("R4 disabled rise ignored", v, 0);
    pins[1] = 0; step(3); rd(0, 5, v); check("R3 fall status", v, 32'h2);
    rd(0, 6, v); check("R3 fall kind 0", v, 0);
    wr(0, 5, 32'h2); wr(0, 1, 0);
  endtask

  task automatic t_level;
    wr(0, 2, 32'h4);
    pins[2] = 1; step(2); rd(0, 5, v); check("R5 high level", v, 32'h4);
    wr(0, 5, 32'h4); rd(0, 5, v); check("R5 level not clearable", v, 32'h4);
    pins[2] = 0; step(2); rd(0, 5, v); check("R5 level drops", v, 0);
    check("R11 irq drops", {31'd0, irq}, 0);
    wr(0, 2, 0);
    wr(0, 3, 32'h10); rd(0, 5, v); check("R6 low level active", v, 32'h10);
    pins[4] = 1; step(2); rd(0, 5, v); check("R6 low level drops", v, 0);
    wr(0, 3, 0); pins[4] = 0; step(2);
  endtask

  task automatic t_excl;
    wr(0, 3, 32'h100);
    wr(0, 2, 32'h100);
    rd(0, 3, v); check("R7 high clears low", v, 0);
    rd(0, 2, v); check("R7 high kept", v, 32'h100);
    wr(0, 3, 32'h300);
    rd(0, 3, v); check("R7 low masked by high", v, 32'h200);
    wr(0, 2, 0); wr(0, 3, 0);
  endtask

  task automatic t_inv;
    wr(0, 4, 32'h20); step(3);
    wr(0, 0, 32'h21);
    pins[5] = 1; step(3); rd(0, 5, v); check("R8 inverted rise ignored", v, 0);
    pins[5] = 0; step(3); rd(0, 5, v); check("R8 inverted fall raises", v, 32'h20);
    rd(0, 6, v); check("R8 kind rising", v, 32'h20);
    wr(0, 5, 32'h20); wr(0, 6, 32'h20);
    wr(0, 0, 32'h1);
  endtask

  task automatic t_bank;
    wr(1, 0, 32'h2);
    pins[33] = 1; step(3);
    rd(1, 5, v); check("R12 bank1 status", v, 32'h2);
    rd(0, 5, v); check("R12 bank0 untouched", v, 0);
    check("R11 irq from bank1", {31'd0, irq}, 1);
    rd(1, 7, v); check("R12 select 7 zero", v, 0);
    wr(1, 5, 32'h2); wr(1, 0, 0);
  endtask

  task automatic t_same;
    pins[0] = 0; step(3);
    pins[0] = 1; step(3);
    pins[0] = 0; step(3);
    rd(0, 5, v); check("R10 precondition", v, 1);
    pins[0] = 1; step(2);
    wr(0, 5, 32'h1);
    rd(0, 5, v); check("R10 set wins over clear", v, 1);
    wr(0, 5, 32'h1);
    rd(0, 5, v); check("R10 later clear works", v, 0);
    check("R11 irq idle", {31'd0, irq}, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    step(3);
    t_reset;
    rst_n = 1;
    step(2);
    t_reset;
    t_rise;
    t_fall;
    t_level;
    t_excl;
    t_inv;
    t_bank;
    t_same;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule